// File: doc/BRIEF.md
# Per-Bank Nonvolatile Command Unlock Detector

This block watches the write strobes on the bus of a memory module built from four identical nonvolatile RAM banks. The upper two address bits pick a bank; the lower eleven address bits and the 8-bit write data feed a three-write unlock sequence. Each bank has its own sequence tracker. Only writes made while the active-low nonvolatile enable input is held low count as sequence steps. Writes made while that input is high are plain RAM writes, and the block ignores them.

A complete sequence ends with a command byte. The block decodes that byte and acts only on the bank that was addressed. The command can turn that bank's autostore-enable flag on or off, or it can raise a one-clock store request to that bank. To reach every bank, software repeats the sequence once for each value of the bank-select bits. The block does not model bus timing or the store operation itself.

Each bank tracker has three states. IDLE waits for the first key. GOT_KEY1 has seen the first key. GOT_KEY2 has seen the second key. Transitions are taken only on a command write, which is a write strobe with nonvolatile enable low.
- IDLE to GOT_KEY1 on key 1, which is data 0xAA at low address 0x555.
- GOT_KEY1 to GOT_KEY2 on key 2, which is data 0x55 at low address 0x2AA.
- GOT_KEY1 stays in GOT_KEY1 on another key 1.
- GOT_KEY2 to IDLE on a command byte written to low address 0x555. This transition executes the command.
- GOT_KEY2 to GOT_KEY1 on key 1.
- Any other command write sends the tracker to IDLE. This includes a command write aimed at a different bank.

Top module: `bank_unlock_detect`

## Requirements
- R1: After reset, all four autostore-enable flags read 1 and all store-request outputs read 0.
- R2: Three command writes to one bank, each with nonvolatile enable low, clear that bank's autostore-enable flag when the sequence is key 1 (0xAA at low address 0x555), key 2 (0x55 at 0x2AA), then 0xCD at 0x555. The flag reads 0 from the clock edge that samples the third write.
- R3: The same sequence ending in command 0xCC sets that bank's autostore-enable flag, with the same timing.
- R4: The same sequence ending in command 0x33 raises that bank's store-request bit for exactly one clock, starting at the edge that samples the third write.
- R5: A command affects only the bank given by address bits 12:11 (bank n is the value n of those bits). The other banks' flags and requests are unchanged.
- R6: A command write with different bank bits, arriving in the middle of a sequence, abandons the sequence in progress. A later step-3 write to the first bank then has no effect.
- R7: A command write that does not match the expected step returns the bank to IDLE. If that write is itself key 1, the bank moves to GOT_KEY1 instead.
- R8: A step-3 write to 0x555 whose byte is not 0xCC, 0xCD or 0x33 has no effect on the outputs and restarts the sequence.
- R9: Writes with nonvolatile enable high do not change outputs or sequence state.
- R10: Cycles with no write strobe do not change sequence state, so steps may be separated by idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| nv_en_n | input | 1 | Nonvolatile enable, active low |
| addr | input | 13 | Write address; bits 12:11 select the bank |
| wdata | input | 8 | Write data |
| as_en | output | 4 | Autostore-enable flag per bank |
| store_req | output | 4 | One-clock store request per bank |

## Verification
The patterns used are as follows.
- Clean sequences ending in each of the three commands, which separate set, clear and pulse behaviour.
- A sweep across all four bank values, which shows that each bank decodes its own select bits.
- A sequence interrupted by a write to another bank, which tells per-bank tracking apart from a single global tracker.
- A repeated key 1, and a wrong second key followed by the right one. These separate restart-at-step-1 from plain reset.
- An unknown command byte, and sequences interleaved with enable-high writes and idle gaps. These show that ordinary writes and idle cycles are transparent.

A behavioural model is compared with the outputs on every clock.

// File: rtl/nvb_pkg.sv
`timescale 1ns/1ps
package nvb_pkg;
    localparam int LO_W   = 11;
    localparam int BYTE_W = 8;

    localparam logic [LO_W-1:0]   KEY1_ADDR = 11'h555;
    localparam logic [LO_W-1:0]   KEY2_ADDR = 11'h2AA;
    localparam logic [LO_W-1:0]   CMD_ADDR  = 11'h555;
    localparam logic [BYTE_W-1:0] KEY1_DATA = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY2_DATA = 8'h55;
    localparam logic [BYTE_W-1:0] OP_AS_ON  = 8'hCC;
    localparam logic [BYTE_W-1:0] OP_AS_OFF = 8'hCD;
    localparam logic [BYTE_W-1:0] OP_STORE  = 8'h33;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GOT_KEY1 = 2'd1,
        ST_GOT_KEY2 = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ASON  = 2'd1,
        CMD_ASOFF = 2'd2,
        CMD_STORE = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/nvb_step_match.sv
`timescale 1ns/1ps
module nvb_step_match
    import nvb_pkg::*;
(
    input  logic [LO_W-1:0]   lo_addr,
    input  logic [BYTE_W-1:0] data,
    output logic              is_key1,
    output logic              is_key2,
    output logic              is_cmd_addr,
    output cmd_kind_e         cmd
);
    always_comb begin
        is_key1     = (lo_addr == KEY1_ADDR) && (data == KEY1_DATA);
        is_key2     = (lo_addr == KEY2_ADDR) && (data == KEY2_DATA);
        is_cmd_addr = (lo_addr == CMD_ADDR);
        unique case (data)
            OP_AS_ON:  cmd = CMD_ASON;
            OP_AS_OFF: cmd = CMD_ASOFF;
            OP_STORE:  cmd = CMD_STORE;
            default:   cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/nvb_bank_fsm.sv
`timescale 1ns/1ps
module nvb_bank_fsm
    import nvb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      other,
    input  logic      is_key1,
    input  logic      is_key2,
    input  logic      is_cmd_addr,
    input  cmd_kind_e cmd,
    output logic      fire_on,
    output logic      fire_off,
    output logic      fire_store
);
    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and command outputs
    always_comb begin
        state_d    = state_q;
        fire_on    = 1'b0;
        fire_off   = 1'b0;
        fire_store = 1'b0;
        if (other) begin
            state_d = ST_IDLE;
        end else if (hit) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = is_key1 ? ST_GOT_KEY1 : ST_IDLE;
                end
                ST_GOT_KEY1: begin
                    if (is_key2)      state_d = ST_GOT_KEY2;
                    else if (is_key1) state_d = ST_GOT_KEY1;
                    else              state_d = ST_IDLE;
                end
                ST_GOT_KEY2: begin
                    if (is_cmd_addr && cmd != CMD_NONE) begin
                        state_d    = ST_IDLE;
                        fire_on    = (cmd == CMD_ASON);
                        fire_off   = (cmd == CMD_ASOFF);
                        fire_store = (cmd == CMD_STORE);
                    end else if (is_key1) begin
                        state_d = ST_GOT_KEY1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nvb_flag_cell.sv
`timescale 1ns/1ps
module nvb_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_on,
    input  logic fire_off,
    input  logic fire_store,
    output logic as_en,
    output logic store_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_en     <= 1'b1;
            store_req <= 1'b0;
        end else begin
            store_req <= fire_store;
            if (fire_on)       as_en <= 1'b1;
            else if (fire_off) as_en <= 1'b0;
        end
    end
endmodule

// File: rtl/bank_unlock_detect.sv
`timescale 1ns/1ps
module bank_unlock_detect
    import nvb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic                 nv_en_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [NUM_BANKS-1:0] as_en,
    output logic [NUM_BANKS-1:0] store_req
);
    localparam int BSEL_W = $clog2(NUM_BANKS);

    logic              cmd_wr;
    logic [BSEL_W-1:0] bank_sel;
    logic              is_key1, is_key2, is_cmd_addr;
    cmd_kind_e         cmd;

    assign cmd_wr   = wr_stb && !nv_en_n;
    assign bank_sel = addr[ADDR_W-1 -: BSEL_W];

    nvb_step_match u_match (
        .lo_addr     (addr[LO_W-1:0]),
        .data        (wdata),
        .is_key1     (is_key1),
        .is_key2     (is_key2),
        .is_cmd_addr (is_cmd_addr),
        .cmd         (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit, other, f_on, f_off, f_store;
        assign hit   = cmd_wr && (bank_sel == BSEL_W'(b));
        assign other = cmd_wr && (bank_sel != BSEL_W'(b));

        nvb_bank_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit         (hit),
            .other       (other),
            .is_key1     (is_key1),
            .is_key2     (is_key2),
            .is_cmd_addr (is_cmd_addr),
            .cmd         (cmd),
            .fire_on     (f_on),
            .fire_off    (f_off),
            .fire_store  (f_store)
        );

        nvb_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire_on    (f_on),
            .fire_off   (f_off),
            .fire_store (f_store),
            .as_en      (as_en[b]),
            .store_req  (store_req[b])
        );
    end
endmodule

// File: rtl/bank_unlock_chk.sv
`timescale 1ns/1ps
module bank_unlock_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_stb,
    input logic                 nv_en_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [7:0]           wdata,
    input logic [NUM_BANKS-1:0] as_en,
    input logic [NUM_BANKS-1:0] store_req
);
    assert_req_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(store_req));

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req != '0) |=> (store_req == '0));

    assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req != '0) |-> $past(wr_stb && !nv_en_n && wdata == 8'h33 && addr[10:0] == 11'h555));

    assert_plain_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && nv_en_n) |-> ($stable(as_en) && store_req == '0));

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((as_en & ~$past(as_en)) != '0) |-> $past(wdata == 8'hCC && wr_stb && !nv_en_n));

    assert_flag_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~as_en & $past(as_en)) != '0) |-> $past(wdata == 8'hCD && wr_stb && !nv_en_n));
endmodule

bind bank_unlock_detect bank_unlock_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_bank_unlock_detect.sv
`timescale 1ns/1ps
module test_bank_unlock_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        nv_en_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  as_en, store_req;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    int m_step [4];
    bit [3:0] m_flag = 4'hF;
    bit [3:0] m_req = 4'h0;

    always #4 clk = ~clk;

    bank_unlock_detect i_bank_unlock_detect (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .nv_en_n(nv_en_n),
        .addr(addr), .wdata(wdata), .as_en(as_en), .store_req(store_req)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_step[k]) m_step[k] = 0;
            m_flag = 4'hF;
            m_req  = 4'h0;
        end else begin
            int  b;
            bit  k1, k2;
            m_req = 4'h0;
            if (wr_stb && !nv_en_n) begin
                b  = int'(addr[12:11]);
                k1 = (addr[10:0] == 11'h555) && (wdata == 8'hAA);
                k2 = (addr[10:0] == 11'h2AA) && (wdata == 8'h55);
                for (int j = 0; j < 4; j++) if (j != b) m_step[j] = 0;
                if (m_step[b] == 2 && addr[10:0] == 11'h555 &&
                    (wdata == 8'hCC || wdata == 8'hCD || wdata == 8'h33)) begin
                    if (wdata == 8'hCC) m_flag[b] = 1'b1;
                    if (wdata == 8'hCD) m_flag[b] = 1'b0;
                    if (wdata == 8'h33) m_req[b]  = 1'b1;
                    m_step[b] = 0;
                end else if (m_step[b] == 1 && k2) m_step[b] = 2;
                else if (k1) m_step[b] = 1;
                else m_step[b] = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (as_en !== m_flag || store_req !== m_req) begin
                n_fail++;
                $display("FAIL %s model compare: as_en=%b store_req=%b expected %b %b",
                         cur_tag, as_en, store_req, m_flag, m_req);
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input bit ne, input bit [1:0] b, input bit [10:0] lo,
                      input bit [7:0] d, input int gap);
        @(negedge clk);
        wr_stb = 1'b1; nv_en_n = ne; addr = {b, lo}; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0; nv_en_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic seq(input bit [1:0] b, input bit [7:0] op);
        wr(1'b0, b, 11'h555, 8'hAA, 0);
        wr(1'b0, b, 11'h2AA, 8'h55, 0);
        wr(1'b0, b, 11'h555, op, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset as_en", as_en, 4'hF);
        chk("R1 reset store_req", store_req, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_tag = "R2";
        seq(2'd0, 8'hCD);
        chk("R2 clear bank0", as_en, 4'b1110);

        cur_tag = "R4";
        seq(2'd2, 8'h33);
        chk("R4 pulse bank2", store_req, 4'b0100);
        @(negedge clk);
        chk("R4 pulse one cycle", store_req, 4'b0000);

        cur_tag = "R3";
        seq(2'd0, 8'hCC);
        chk("R3 set bank0", as_en, 4'b1111);

        cur_tag = "R5";
        seq(2'd3, 8'hCD);
        chk("R5 only bank3", as_en, 4'b0111);
        for (int b = 0; b < 3; b++) seq(2'(b), 8'hCD);
        chk("R5 all banks cleared", as_en, 4'b0000);

        cur_tag = "R6";
        wr(1'b0, 2'd1, 11'h555, 8'hAA, 0);
        wr(1'b0, 2'd1, 11'h2AA, 8'h55, 0);
        wr(1'b0, 2'd3, 11'h555, 8'hAA, 0);
        wr(1'b0, 2'd1, 11'h555, 8'hCC, 1);
        chk("R6 interrupted sequence", as_en, 4'b0000);

        cur_tag = "R7";
        wr(1'b0, 2'd1, 11'h555, 8'hAA, 0);
        wr(1'b0, 2'd1, 11'h555, 8'hAA, 0);
        wr(1'b0, 2'd1, 11'h2AA, 8'h55, 0);
        wr(1'b0, 2'd1, 11'h555, 8'hCC, 0);
        chk("R7 repeated key1 restarts", as_en, 4'b0010);
        wr(1'b0, 2'd2, 11'h555, 8'hAA, 0);
        wr(1'b0, 2'd2, 11'h2AA, 8'h12, 0);
        wr(1'b0, 2'd2, 11'h2AA, 8'h55, 0);
        wr(1'b0, 2'd2, 11'h555, 8'hCC, 1);
        chk("R7 wrong key2 resets", as_en, 4'b0010);

        cur_tag = "R8";
        seq(2'd3, 8'h77);
        chk("R8 unknown op flags", as_en, 4'b0010);
        chk("R8 unknown op req", store_req, 4'b0000);
        wr(1'b0, 2'd3, 11'h555, 8'hCC, 1);
        chk("R8 sequence restarted", as_en, 4'b0010);

        cur_tag = "R9";
        wr(1'b0, 2'd2, 11'h555, 8'hAA, 2);
        wr(1'b1, 2'd2, 11'h123, 8'h99, 0);
        wr(1'b0, 2'd2, 11'h2AA, 8'h55, 3);
        wr(1'b1, 2'd0, 11'h555, 8'hCC, 0);
        chk("R9 plain write no effect", as_en, 4'b0010);
        wr(1'b0, 2'd2, 11'h555, 8'hCC, 0);
        chk("R9 R10 sequence survives", as_en, 4'b0110);
        wr(1'b1, 2'd3, 11'h555, 8'hAA, 0);
        wr(1'b1, 2'd3, 11'h2AA, 8'h55, 0);
        wr(1'b1, 2'd3, 11'h555, 8'h33, 0);
        chk("R9 enable-high sequence req", store_req, 4'b0000);
        chk("R9 enable-high sequence flags", as_en, 4'b0110);

        cur_tag = "R10";
        wr(1'b0, 2'd0, 11'h555, 8'hAA, 5);
        wr(1'b0, 2'd0, 11'h2AA, 8'h55, 5);
        wr(1'b0, 2'd0, 11'h555, 8'h33, 0);
        chk("R10 gapped store pulse", store_req, 4'b0001);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_tag);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule